// File: doc/BRIEF.md
# Seven-to-One Pixel Link Serializer

This block turns a 28-bit parallel pixel word, presented once per pixel clock period, into four serial data lanes and one forwarded clock lane. Each lane carries seven bit slots per pixel period. The bit clock runs at seven times the pixel rate and comes from outside the block. An external frame mark input gives the bit clock's phase, so the block knows where a serial frame begins.

The block captures the pixel word in a holding register. A select input chooses whether this happens on the rising or the falling pixel clock edge. The held word is loaded into five per-lane shift registers at slot 0 of the next serial frame, so a word is never split across two frames. Each data lane takes seven fixed input bits in a fixed, non-sequential slot order. The clock lane repeats a pattern of four high slots followed by three low slots.

A sequencer in the bit clock domain has three states:
- `ST_OFF`: shutdown is asserted.
- `ST_LOCK`: shutdown has been released and the block waits `LOCK_CYCLES` bit clocks for the external clock to settle.
- `ST_RUN`: the lanes are live.

Transitions:
- Off-to-lock happens when `shut` is low.
- Lock-to-run happens once the count has expired and the next cycle is slot 0.
- Any state returns to off when `shut` is high.

Outside `ST_RUN`, the output-enable is low and all lanes drive 0.

Top module: `pixel_link_ser`

## Requirements
- R1: With `edge_rise`=1 the word is captured on the rising `pclk` edge; with 0, on the falling edge. A captured word is sent in the first frame whose slot 0 begins after the capture.
- R2: Lane 0 (`lane_d[0]`) sends, in slots 0..6, word bits 1, 0, 7, 6, 4, 3, 2.
- R3: Lane 1 (`lane_d[1]`) sends, in slots 0..6, word bits 9, 8, 18, 15, 14, 13, 12.
- R4: Lane 2 (`lane_d[2]`) sends, in slots 0..6, word bits 20, 19, 26, 25, 24, 22, 21.
- R5: Lane 3 (`lane_d[3]`) sends, in slots 0..6, word bits 5, 27, 23, 17, 16, 11, 10.
- R6: While enabled, `lane_clk` is 1 in slots 0..3 and 0 in slots 4..6, which gives it a period of seven bit clocks.
- R7: The bit clock cycle after one in which `frame_mark` is sampled high is slot 0. Otherwise the slot advances by one and wraps from 6 to 0.
- R8: From the first bit clock edge that samples `shut` high, `lane_oe`, `lane_clk` and all of `lane_d` are 0, whatever the pixel input.
- R9: After `shut` is sampled low, `lane_oe` stays 0 for at least `LOCK_CYCLES`+1 bit clocks and rises only at slot 0. Raising `shut` during the wait restarts the count.
- R10: During reset, `lane_oe`, `lane_clk` and `lane_d` are 0, the slot counter is 0 and the state is `ST_OFF`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock, seven times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_mark | input | 1 | Phase mark; the next bit clock cycle is slot 0 |
| shut | input | 1 | Shutdown request, synchronous to `bclk` |
| pclk | input | 1 | Pixel clock |
| edge_rise | input | 1 | 1 selects rising-edge capture, 0 selects falling-edge capture |
| pix_in | input | 28 | Parallel pixel word |
| lane_d | output | 4 | Serial data lanes |
| lane_clk | output | 1 | Forwarded clock lane |
| lane_oe | output | 1 | Lane output enable; high only in `ST_RUN` |

## Verification
The bench builds the block with `LOCK_CYCLES` set to 20. This keeps the lock wait short enough that the exact entry window into `ST_RUN` can be measured several times, including a restart in the middle of the wait. With that setting, the run covers:
- both capture edges, each with its own frame latency;
- a walking single bit across all 28 inputs, which pins each lane and slot to exactly one source bit;
- a forced phase jump on `frame_mark`, followed by checks on the clock lane and the data.

// File: rtl/plser_pkg.sv
package plser_pkg;

    localparam int LANES      = 4;
    localparam int SLOTS      = 7;
    localparam int WORD_W     = LANES * SLOTS;
    localparam int HIGH_SLOTS = 4;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_LOCK = 2'd1,
        ST_RUN  = 2'd2
    } link_st_t;

    // Source word bit for a given lane and slot.
    function automatic int src_bit(input int lane, input int slot);
        case (lane * SLOTS + slot)
            0:  return 1;   1:  return 0;   2:  return 7;   3:  return 6;
            4:  return 4;   5:  return 3;   6:  return 2;
            7:  return 9;   8:  return 8;   9:  return 18;  10: return 15;
            11: return 14;  12: return 13;  13: return 12;
            14: return 20;  15: return 19;  16: return 26;  17: return 25;
            18: return 24;  19: return 22;  20: return 21;
            21: return 5;   22: return 27;  23: return 23;  24: return 17;
            25: return 16;  26: return 11;  27: return 10;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/plser_capture.sv
module plser_capture #(
    parameter int W = 28
) (
    input  logic         pclk,
    input  logic         rst_n,
    input  logic         edge_rise,
    input  logic [W-1:0] pix_in,
    output logic [W-1:0] hold
);

    logic [W-1:0] hold_r;
    logic [W-1:0] hold_f;

    always_ff @(posedge pclk or negedge rst_n) begin
        if (!rst_n) hold_r <= '0;
        else        hold_r <= pix_in;
    end

    always_ff @(negedge pclk or negedge rst_n) begin
        if (!rst_n) hold_f <= '0;
        else        hold_f <= pix_in;
    end

    assign hold = edge_rise ? hold_r : hold_f;

endmodule

// File: rtl/plser_lane_shift.sv
module plser_lane_shift #(
    parameter int N = 7
) (
    input  logic         bclk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [N-1:0] vec,
    output logic         ser
);

    logic [N-1:0] sh_q;

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n)    sh_q <= '0;
        else if (load) sh_q <= vec;
        else           sh_q <= {1'b0, sh_q[N-1:1]};
    end

    assign ser = sh_q[0];

endmodule

// File: rtl/plser_seq.sv
module plser_seq
    import plser_pkg::*;
#(
    parameter int SLOT_N      = 7,
    parameter int LOCK_CYCLES = 1000
) (
    input  logic                        bclk,
    input  logic                        rst_n,
    input  logic                        frame_mark,
    input  logic                        shut,
    output logic [$clog2(SLOT_N)-1:0]   slot,
    output logic                        frame_load,
    output logic                        run
);

    localparam int SW = $clog2(SLOT_N);
    localparam int CW = $clog2(LOCK_CYCLES + 1);

    link_st_t        state_q, state_nxt;
    logic [SW-1:0]   slot_q, slot_nxt;
    logic [CW-1:0]   cnt_q;
    logic            lock_done;

    always_comb begin
        if (frame_mark)                      slot_nxt = '0;
        else if (slot_q == SW'(SLOT_N - 1))  slot_nxt = '0;
        else                                 slot_nxt = slot_q + 1'b1;
    end

    assign lock_done = (cnt_q == CW'(LOCK_CYCLES));

    // Next-state logic.
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_OFF:  if (!shut) state_nxt = ST_LOCK;
            ST_LOCK: begin
                if (shut)                                state_nxt = ST_OFF;
                else if (lock_done && slot_nxt == '0)    state_nxt = ST_RUN;
            end
            ST_RUN:  if (shut) state_nxt = ST_OFF;
            default: state_nxt = ST_OFF;
        endcase
    end

    // State register, slot counter and lock counter.
    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            slot_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_nxt;
            slot_q  <= slot_nxt;
            if (state_q != ST_LOCK) cnt_q <= '0;
            else if (!lock_done)    cnt_q <= cnt_q + 1'b1;
        end
    end

    // Outputs.
    always_comb begin
        run        = (state_q == ST_RUN);
        frame_load = (slot_nxt == '0);
        slot       = slot_q;
    end

    a_r8_shut_forces_off: assert property (@(posedge bclk) disable iff (!rst_n)
        shut |=> state_q == ST_OFF);

    a_r7_mark_aligns: assert property (@(posedge bclk) disable iff (!rst_n)
        frame_mark |=> slot_q == '0);

    a_r7_slot_steps: assert property (@(posedge bclk) disable iff (!rst_n)
        (!frame_mark && slot_q != SW'(SLOT_N - 1)) |=> slot_q == $past(slot_q) + 1'b1);

    a_r9_lock_served: assert property (@(posedge bclk) disable iff (!rst_n)
        (state_q == ST_RUN && $past(state_q) == ST_LOCK) |-> $past(cnt_q) == CW'(LOCK_CYCLES));

endmodule

// File: rtl/pixel_link_ser.sv
module pixel_link_ser
    import plser_pkg::*;
#(
    parameter int LOCK_CYCLES = 1000
) (
    input  logic              bclk,
    input  logic              rst_n,
    input  logic              frame_mark,
    input  logic              shut,
    input  logic              pclk,
    input  logic              edge_rise,
    input  logic [WORD_W-1:0] pix_in,
    output logic [LANES-1:0]  lane_d,
    output logic              lane_clk,
    output logic              lane_oe
);

    localparam int SW = $clog2(SLOTS);

    logic [WORD_W-1:0] hold;
    logic [SLOTS-1:0]  lane_vec [LANES];
    logic [SLOTS-1:0]  clk_vec;
    logic [LANES-1:0]  ser;
    logic              clk_ser;
    logic [SW-1:0]     slot;
    logic              frame_load;
    logic              run;

    plser_capture #(.W(WORD_W)) cap_i (
        .pclk      (pclk),
        .rst_n     (rst_n),
        .edge_rise (edge_rise),
        .pix_in    (pix_in),
        .hold      (hold)
    );

    plser_seq #(.SLOT_N(SLOTS), .LOCK_CYCLES(LOCK_CYCLES)) seq_i (
        .bclk       (bclk),
        .rst_n      (rst_n),
        .frame_mark (frame_mark),
        .shut       (shut),
        .slot       (slot),
        .frame_load (frame_load),
        .run        (run)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            assign lane_vec[l][s] = hold[src_bit(l, s)];
        end
        plser_lane_shift #(.N(SLOTS)) sh_i (
            .bclk  (bclk),
            .rst_n (rst_n),
            .load  (frame_load),
            .vec   (lane_vec[l]),
            .ser   (ser[l])
        );
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_clk_shape
        assign clk_vec[s] = (s < HIGH_SLOTS);
    end

    plser_lane_shift #(.N(SLOTS)) clk_sh_i (
        .bclk  (bclk),
        .rst_n (rst_n),
        .load  (frame_load),
        .vec   (clk_vec),
        .ser   (clk_ser)
    );

    assign lane_d   = run ? ser : '0;
    assign lane_clk = run & clk_ser;
    assign lane_oe  = run;

    a_r6_clock_shape: assert property (@(posedge bclk) disable iff (!rst_n)
        lane_oe |-> lane_clk == (slot < SW'(HIGH_SLOTS)));

    a_r9_run_at_slot0: assert property (@(posedge bclk) disable iff (!rst_n)
        $rose(lane_oe) |-> slot == '0);

endmodule

// File: tb/pixel_link_ser_tb_top.sv
module pixel_link_ser_tb_top;

    localparam int LOCK = 20;

    logic        bclk = 0, pclk = 0, rst_n = 0, edge_rise = 1, shut = 1, jump = 0;
    logic [27:0] pix = '0;
    logic [3:0]  lane_d;
    logic        lane_clk, lane_oe;
    logic        frame_mark;
    int          bc = 0;
    int          n_chk = 0, n_bad = 0;

    int tb_map [28] = '{1, 0, 7, 6, 4, 3, 2,
                        9, 8, 18, 15, 14, 13, 12,
                        20, 19, 26, 25, 24, 22, 21,
                        5, 27, 23, 17, 16, 11, 10};
    string lane_tag [4] = '{"R2", "R3", "R4", "R5"};

    assign frame_mark = (bc == 6) || jump;

    always #5 bclk = ~bclk;
    always @(posedge bclk) bc <= frame_mark ? 0 : bc + 1;
    always @(negedge bclk) pclk <= (bc <= 3);

    pixel_link_ser #(.LOCK_CYCLES(LOCK)) dut_i (
        .bclk       (bclk),
        .rst_n      (rst_n),
        .frame_mark (frame_mark),
        .shut       (shut),
        .pclk       (pclk),
        .edge_rise  (edge_rise),
        .pix_in     (pix),
        .lane_d     (lane_d),
        .lane_clk   (lane_clk),
        .lane_oe    (lane_oe)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_slot(input int s);
        do @(negedge bclk); while (bc != s);
    endtask

    task automatic t_reset();
        @(negedge bclk);
        chk(lane_oe == 0 && lane_d == 0 && lane_clk == 0, "R10 reset outputs",
            {lane_oe, lane_clk, lane_d}, 0);
        rst_n = 1;
    endtask

    // Release shut and measure cycles until the enable rises.
    task automatic t_lock(input string tag);
        int k = 0;
        bit quiet = 1;
        shut = 0;
        do begin
            @(negedge bclk);
            k++;
            if (!lane_oe && (lane_d != 0 || lane_clk)) quiet = 0;
        end while (!lane_oe && k < 300);
        chk(k >= LOCK + 2 && k <= LOCK + 8, {tag, " R9 lock wait"}, k, LOCK + 2);
        chk(bc == 0, {tag, " R9 run begins at slot 0"}, bc, 0);
        chk(quiet, {tag, " R8 lanes quiet while locking"}, quiet, 1);
    endtask

    task automatic t_frames(input bit rise, input int n, input bit walk, input string tag);
        logic [27:0] w [40];
        int lat = rise ? 2 : 1;
        edge_rise = rise;
        wait_slot(6);
        for (int i = 0; i < n; i++) begin
            logic [6:0] rx [4];
            logic [6:0] cb;
            for (int s = 0; s < 7; s++) begin
                @(negedge bclk);
                if (s == 2) begin
                    w[i] = walk ? 28'(1) << (i % 28) : 28'($urandom);
                    pix  = w[i];
                end
                for (int l = 0; l < 4; l++) rx[l][s] = lane_d[l];
                cb[s] = lane_clk;
            end
            chk(cb == 7'b0001111, {tag, " R6 clock lane shape"}, cb, 7'b0001111);
            if (i >= lat) begin
                for (int l = 0; l < 4; l++) begin
                    logic [6:0] e;
                    for (int s = 0; s < 7; s++) e[s] = w[i - lat][tb_map[l * 7 + s]];
                    chk(rx[l] == e, {tag, " R1 ", lane_tag[l], " lane bits"}, rx[l], e);
                end
            end
        end
    endtask

    task automatic t_shut();
        bit quiet = 1;
        wait_slot(3);
        shut = 1;
        for (int c = 0; c < 12; c++) begin
            @(negedge bclk);
            pix = 28'($urandom) | 28'h1;
            if (lane_oe || lane_d != 0 || lane_clk) quiet = 0;
        end
        chk(quiet, "R8 shutdown forces lanes off", quiet, 1);
        t_lock("after shutdown");
    endtask

    task automatic t_restart();
        bit low = 1;
        wait_slot(1);
        shut = 1;
        repeat (3) @(negedge bclk);
        shut = 0;
        for (int c = 0; c < 8; c++) begin
            @(negedge bclk);
            if (lane_oe) low = 0;
        end
        shut = 1;
        repeat (3) @(negedge bclk);
        chk(low && !lane_oe, "R9 enable low during partial lock", lane_oe, 0);
        t_lock("restart");
    endtask

    task automatic t_realign();
        logic [6:0] cb;
        wait_slot(3);
        jump = 1;
        @(negedge bclk);
        jump = 0;
        cb[0] = lane_clk;
        for (int s = 1; s < 7; s++) begin
            @(negedge bclk);
            cb[s] = lane_clk;
        end
        chk(cb == 7'b0001111, "R7 slot 0 follows frame mark", cb, 7'b0001111);
        t_frames(1'b0, 4, 1'b0, "post-jump");
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge bclk);
        t_reset();
        repeat (2) @(negedge bclk);
        t_lock("first");
        t_frames(1'b1, 8, 1'b0, "rise random");
        t_frames(1'b0, 8, 1'b0, "fall random");
        t_frames(1'b1, 31, 1'b1, "rise walk");
        t_frames(1'b0, 30, 1'b1, "fall walk");
        t_shut();
        t_frames(1'b1, 5, 1'b0, "after shut");
        t_restart();
        t_realign();
        finish_run();
    end

endmodule